// File: doc/BRIEF.md
# Three-Phase Current-Error Carrier Modulator

This block produces the gate commands for a three-leg voltage source converter that is run as a shunt current compensator. For each leg it subtracts the sensed source current from the reference source current and multiplies that difference by a proportional gain. There is no integral term. The scaled result is clamped to the carrier's span and compared with a symmetric triangular carrier that all three legs share. The compare result drives a complementary pair of gate lines per leg. Every turn-on edge is held back by a programmable dead time.

Current samples arrive as signed integers. The gain is an unsigned fixed-point value with four fractional bits. The carrier is an up/down counter clocked by the system clock. With the default span of ±2500 and a 100 MHz clock, it gives a 10 kHz switching period. A low enable drives all six gate lines low at once. When enable rises, the first turn-on is delayed by the dead time.

Top module: `cc_pwm_mod`

## Requirements
- R1: For each leg, the modulating value is floor(((iref − isen) × kp) / 16), using signed arithmetic and an arithmetic right shift. The gain `kp` is unsigned with 4 fractional bits, so 16 means unity. The value depends only on the present error and has no accumulation.
- R2: The modulating value is clamped to the range −CAR_AMP to +CAR_AMP (default ±2500) before the comparison.
- R3: The carrier starts at −CAR_AMP after reset and moves by one step every clock. It rises to +CAR_AMP, falls back to −CAR_AMP, and repeats with a period of 4×CAR_AMP clocks (10000 by default).
- R4: The upper switch of a leg is commanded on while the clamped modulating value is strictly greater than the carrier. The lower switch is commanded on otherwise. Over one carrier period with dead time 0 and a value m inside the range, the upper line is high for 2(m+CAR_AMP)−1 clocks. At m = −CAR_AMP it is high for 0 clocks.
- R5: Whenever a leg's commanded state changes, both lines of that leg stay low for `dead_clks` clocks (0 to 255) before the new line turns on. The two lines of one leg are never high together.
- R6: While `en` is low, all six gate lines are low. After `en` rises, every line stays low for `dead_clks` clocks.
- R7: While `rst_n` is low, all six gate lines are low.
- R8: The legs are independent. Bit 0, 1 and 2 of each gate bus belong to legs a, b and c. The upper lines `gate_hi[0..2]` are switches S1, S3 and S5. The lower lines `gate_lo[0..2]` are switches S4, S6 and S2, so the pairs are S1/S4, S3/S6 and S5/S2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Modulator enable |
| kp | input | GW (8) | Proportional gain, unsigned, 4 fractional bits |
| dead_clks | input | DTW (8) | Dead time in clocks |
| iref_a | input | DW (16) | Reference current, leg a, signed |
| iref_b | input | DW (16) | Reference current, leg b, signed |
| iref_c | input | DW (16) | Reference current, leg c, signed |
| isen_a | input | DW (16) | Sensed current, leg a, signed |
| isen_b | input | DW (16) | Sensed current, leg b, signed |
| isen_c | input | DW (16) | Sensed current, leg c, signed |
| gate_hi | output | 3 | Upper switch commands (S1, S3, S5) |
| gate_lo | output | 3 | Lower switch commands (S4, S6, S2) |

## Verification
A corrupted carrier count or direction bit shifts the high-time per period of every leg at once. A corrupted product, shift or clamp shifts only the affected leg. For that reason the bench counts the high clocks of each line over a whole 10000-clock window, after letting the inputs settle for one period, and compares the counts against the closed-form duty from R4. A stale dead-time counter or state bit shows up as a wrong overlap count within one switching edge, so it is caught by per-leg overlap properties in the cycle it occurs. An exact edge-to-edge period check catches a wrong turnaround point within two carrier periods.

// File: rtl/cc_pwm_mod.sv
module cc_pwm_mod #(
  parameter int DW      = 16,
  parameter int GW      = 8,
  parameter int GFRAC   = 4,
  parameter int CAR_AMP = 2500,
  parameter int DTW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [GW-1:0]        kp,
  input  logic [DTW-1:0]       dead_clks,
  input  logic signed [DW-1:0] iref_a,
  input  logic signed [DW-1:0] iref_b,
  input  logic signed [DW-1:0] iref_c,
  input  logic signed [DW-1:0] isen_a,
  input  logic signed [DW-1:0] isen_b,
  input  logic signed [DW-1:0] isen_c,
  output logic [2:0]           gate_hi,
  output logic [2:0]           gate_lo
);

  localparam int CW = $clog2(CAR_AMP + 1) + 1;
  localparam int PW = DW + GW + 2;
  localparam logic signed [CW-1:0] C_TOP = CW'(CAR_AMP);
  localparam logic signed [CW-1:0] C_BOT = CW'(-CAR_AMP);
  localparam logic signed [PW-1:0] S_TOP = PW'(CAR_AMP);
  localparam logic signed [PW-1:0] S_BOT = PW'(-CAR_AMP);

  logic signed [DW-1:0] ref_v [3];
  logic signed [DW-1:0] sen_v [3];

  assign ref_v[0] = iref_a;
  assign ref_v[1] = iref_b;
  assign ref_v[2] = iref_c;
  assign sen_v[0] = isen_a;
  assign sen_v[1] = isen_b;
  assign sen_v[2] = isen_c;

  logic signed [CW-1:0] car;
  logic                 car_up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      car    <= C_BOT;
      car_up <= 1'b1;
    end else if (car_up) begin
      if (car == C_TOP - CW'(1)) car_up <= 1'b0;
      car <= car + CW'(1);
    end else begin
      if (car == C_BOT + CW'(1)) car_up <= 1'b1;
      car <= car - CW'(1);
    end
  end

  logic signed [PW-1:0] gain_s;
  assign gain_s = PW'($signed({1'b0, kp}));

  for (genvar k = 0; k < 3; k++) begin : g_leg
    logic signed [DW:0]    err;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  scl;
    logic signed [CW-1:0]  mod_q;
    logic                  want;
    logic                  st;
    logic [DTW-1:0]        cnt;

    assign err  = $signed({ref_v[k][DW-1], ref_v[k]}) - $signed({sen_v[k][DW-1], sen_v[k]});
    assign prod = PW'(err) * gain_s;
    assign scl  = prod >>> GFRAC;

    always_ff @(posedge clk) begin
      if (!rst_n)            mod_q <= '0;
      else if (scl > S_TOP)  mod_q <= C_TOP;
      else if (scl < S_BOT)  mod_q <= C_BOT;
      else                   mod_q <= CW'(scl);
    end

    assign want = mod_q > car;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st  <= 1'b0;
        cnt <= '0;
      end else begin
        st <= want;
        if (!en || want != st) cnt <= dead_clks;
        else if (cnt != '0)    cnt <= cnt - DTW'(1);
      end
    end

    assign gate_hi[k] = rst_n & en &  st & (cnt == '0);
    assign gate_lo[k] = rst_n & en & ~st & (cnt == '0);
  end

endmodule

// File: rtl/cc_pwm_mod_chk.sv
module cc_pwm_mod_chk #(
  parameter int CW      = 13,
  parameter int CAR_AMP = 2500,
  parameter int DTW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic [DTW-1:0]       dead_clks,
  input logic signed [CW-1:0] car,
  input logic [2:0]           gate_hi,
  input logic [2:0]           gate_lo
);

  localparam logic signed [CW-1:0] C_TOP = CW'(CAR_AMP);
  localparam logic signed [CW-1:0] C_BOT = CW'(-CAR_AMP);

  logic live;
  always_ff @(posedge clk) live <= rst_n;

  assert_car_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (car <= C_TOP) && (car >= C_BOT));

  assert_car_moves_R3: assert property (@(posedge clk) disable iff (!rst_n || !live)
    car != $past(car));

  assert_car_turn_top_R3: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ($past(car) == C_TOP) |-> (car == C_TOP - CW'(1)));

  assert_car_turn_bot_R3: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ($past(car) == C_BOT) |-> (car == C_BOT + CW'(1)));

  assert_disabled_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  for (genvar k = 0; k < 3; k++) begin : g_leg_chk
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[k] && gate_lo[k]));

    assert_gap_hi_R5: assert property (@(posedge clk) disable iff (!rst_n || !live)
      ($rose(gate_hi[k]) && dead_clks != '0 && $stable(dead_clks)) |-> !$past(gate_lo[k]));

    assert_gap_lo_R5: assert property (@(posedge clk) disable iff (!rst_n || !live)
      ($rose(gate_lo[k]) && dead_clks != '0 && $stable(dead_clks)) |-> !$past(gate_hi[k]));
  end

endmodule

bind cc_pwm_mod cc_pwm_mod_chk #(.CW(CW), .CAR_AMP(CAR_AMP), .DTW(DTW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .dead_clks (dead_clks),
  .car       (car),
  .gate_hi   (gate_hi),
  .gate_lo   (gate_lo)
);

// File: tb/cc_pwm_mod_tb.sv
module cc_pwm_mod_tb;

  localparam int PER = 10000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b0;
  logic [7:0]         kp = 8'd16;
  logic [7:0]         dead_clks = 8'd0;
  logic signed [15:0] iref_a = '0, iref_b = '0, iref_c = '0;
  logic signed [15:0] isen_a = '0, isen_b = '0, isen_c = '0;
  logic [2:0]         gate_hi, gate_lo;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cc_pwm_mod u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .kp(kp), .dead_clks(dead_clks),
    .iref_a(iref_a), .iref_b(iref_b), .iref_c(iref_c),
    .isen_a(isen_a), .isen_b(isen_b), .isen_c(isen_c),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_leg(input int k, input int r, input int s);
    case (k)
      0: begin iref_a = 16'(r); isen_a = 16'(s); end
      1: begin iref_b = 16'(r); isen_b = 16'(s); end
      default: begin iref_c = 16'(r); isen_c = 16'(s); end
    endcase
  endtask

  task automatic measure(input string req, input int ea_hi, input int ea_lo,
                         input int eb_hi, input int eb_lo,
                         input int ec_hi, input int ec_lo);
    int hi [3];
    int lo [3];
    for (int k = 0; k < 3; k++) begin hi[k] = 0; lo[k] = 0; end
    repeat (PER) @(negedge clk);
    for (int n = 0; n < PER; n++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        hi[k] += int'(gate_hi[k]);
        lo[k] += int'(gate_lo[k]);
      end
    end
    check({req, " leg a hi"}, hi[0], ea_hi);
    check({req, " leg a lo"}, lo[0], ea_lo);
    check({req, " leg b hi"}, hi[1], eb_hi);
    check({req, " leg b lo"}, lo[1], eb_lo);
    check({req, " leg c hi"}, hi[2], ec_hi);
    check({req, " leg c lo"}, lo[2], ec_lo);
  endtask

  task automatic t_reset;
    en = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 gates during reset", int'({gate_hi, gate_lo}), 0);
    en = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_disable;
    int bad = 0;
    for (int k = 0; k < 3; k++) set_leg(k, 1000, 0);
    en = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if ({gate_hi, gate_lo} != 6'd0) bad++;
    end
    check("R6 enable low keeps gates off", bad, 0);
  endtask

  task automatic t_enable_rise;
    int early = 0;
    kp = 8'd16;
    dead_clks = 8'd20;
    for (int k = 0; k < 3; k++) set_leg(k, 0, 4000);
    en = 1'b0;
    repeat (50) @(negedge clk);
    en = 1'b1;
    #1;
    for (int s = 0; s <= 20; s++) begin
      if (s > 0) @(negedge clk);
      if (s < 20 && {gate_hi, gate_lo} != 6'd0) early++;
      if (s == 20) check("R6 lower lines on after dead time", int'(gate_lo), 7);
    end
    check("R6 gates low during dead time after enable", early, 0);
  endtask

  task automatic t_mixed;
    kp = 8'd32;
    dead_clks = 8'd10;
    set_leg(0, 1000, 400);
    set_leg(1, 0, 1000);
    set_leg(2, 123, 123);
    // R4 R5 R8: m = 1200, -2000, 0 with dead time 10
    measure("R4/R5/R8 mixed", 7389, 2591, 989, 8991, 4989, 4991);
  endtask

  task automatic t_saturate;
    kp = 8'd16;
    dead_clks = 8'd0;
    set_leg(0, 4000, 0);
    set_leg(1, -4000, 0);
    set_leg(2, 2499, 0);
    // R2: clamps to +2500 / -2500, leg c just inside
    measure("R2 saturation", 9999, 1, 0, 10000, 9997, 3);
  endtask

  task automatic t_gain;
    kp = 8'd3;
    dead_clks = 8'd0;
    set_leg(0, 5, 0);
    set_leg(1, 0, 5);
    set_leg(2, 8533, 0);
    // R1: floor(15/16)=0, floor(-15/16)=-1, floor(25599/16)=1599
    measure("R1 gain and floor", 4999, 5001, 4997, 5003, 8197, 1803);
  endtask

  task automatic t_period;
    int gap = 0;
    int lim = 0;
    logic prev;
    prev = gate_hi[0];
    while (!(gate_hi[0] && !prev) && lim < 2 * PER) begin
      prev = gate_hi[0];
      @(negedge clk);
      lim++;
    end
    prev = gate_hi[0];
    lim = 0;
    do begin
      @(negedge clk);
      gap++;
      lim = int'(gate_hi[0] && !prev);
      prev = gate_hi[0];
    end while (lim == 0 && gap < 2 * PER);
    check("R3 carrier period", gap, PER);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_disable();
    t_enable_rise();
    t_mixed();
    t_saturate();
    t_gain();
    t_period();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule